// File: doc/BRIEF.md
# Spread-Spectrum Serial Bit Clock Generator

This block times the bits of a serial bus so that no two neighbouring bits need have the same length. The goal is to spread radiated energy over many frequencies instead of one line. It runs from a 64 MHz timing clock. Every bit lasts a programmable minimum number of ticks plus a pseudo-random extra count. The extra count is clipped by a programmable deviation limit, so the system designer controls how long the longest bit can be.

The minimum comes from an 8-bit base setting: twice the setting, plus 320 ticks. The extra count is taken from a 24-bit linear feedback shift register, which advances once per bit. A 3-bit deviation field keeps only the low bits of that value. The block drives a square-wave bit clock. It also exposes the length of the bit in progress and the number of ticks left in it, so that a monitor or the bus driver can follow the timing.

Top module: `ssb_clock_spreader`

## Requirements
- R1: While reset is held, and just after it, `bit_clk` is 0, `bit_remain` is 0 and `bit_period` is 0.
- R2: Each bit's length in ticks, reported on `bit_period`, equals 320 + 2*B + (X & M). B is `base_sel`, X is the random value (R3) and M is the deviation mask (R4). The same value appears on `bit_remain` in the first cycle of the bit.
- R3: X is bits 6..0 of a 24-bit shift register seeded to 24'h5A5A5A by reset. X is read from the state held before the step. At each bit load the register shifts toward bit 23, and its new bit 0 is the XOR of bits 23, 22, 21 and 16.
- R4: For `dev_sel` = D, M has its low D+1 bits set, so M = 1, 3, 7, ... 127. D = 7 gives M = 127.
- R5: `bit_remain` counts down by one per enabled cycle, from the loaded length to 1. The next bit loads in the cycle after `bit_remain` is 1, so each bit lasts exactly its length in enabled cycles.
- R6: `bit_clk` is 1 for the first floor(P/2) enabled cycles of a bit of length P and 0 for the rest.
- R7: `base_sel` and `dev_sel` are sampled only when a bit is loaded. Changing them during a bit leaves that bit's length unchanged, and the next bit uses the new values.
- R8: While `enable` is 0, `bit_clk` is 0, and the count, the reported length and the random sequence are all frozen. The first bit after reset loads at the first enabled clock edge.
- R9: No bit is shorter than 320 + 2*B or longer than 320 + 2*B + M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 64 MHz timing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator when 1; freezes it and forces the bit clock low when 0 |
| base_sel | input | 8 | Base period setting B |
| dev_sel | input | 3 | Deviation limit setting D |
| bit_clk | output | 1 | Square-wave bit clock |
| bit_remain | output | 10 | Ticks left in the current bit, including this one |
| bit_period | output | 10 | Length in ticks of the current bit |

## Verification
The hardest case to reach from the ports is a setting change or an enable drop in the middle of a bit. Both must leave the bit in progress untouched and must not advance the random sequence. The bench sweeps every deviation setting across several base settings, including 0 and 255. For each pair it rewrites the settings ten cycles into a bit and pauses the generator during the high phase of some bits. A per-bit model of the shift register then checks that the bit length, the high-phase length and the next random value all stay exact.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  parameter int BASE_W      = 8;
  parameter int DEV_W       = 3;
  parameter int RND_W       = 7;
  parameter int LFSR_W      = 24;
  parameter int BASE_OFFSET = 320;

  localparam int MAX_TICKS = BASE_OFFSET + 2 * ((1 << BASE_W) - 1) + (1 << RND_W) - 1;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  // feedback taps: state bits 23, 22, 21 and 16
  localparam logic [LFSR_W-1:0] TAP_MASK = LFSR_W'(24'hE1_0000);

  typedef logic [CNT_W-1:0] ticks_t;

  // minimum bit length in ticks for a base setting
  function automatic ticks_t base_ticks(input logic [BASE_W-1:0] b);
    return ticks_t'(BASE_OFFSET) + ticks_t'({b, 1'b0});
  endfunction

  // low (d+1) bits set, saturating at the full random width
  function automatic logic [RND_W-1:0] dev_mask(input logic [DEV_W-1:0] d);
    logic [RND_W-1:0] m;
    for (int i = 0; i < RND_W; i++) m[i] = (i <= int'(d));
    return m;
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], ^(s & TAP_MASK)};
  endfunction
endpackage

// File: rtl/ssb_prbs.sv
module ssb_prbs
  import ssb_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 24'h5A5A5A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [RND_W-1:0] rnd
);
  logic [LFSR_W-1:0] state;

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= lfsr_step(state);
  end

  assign rnd = state[RND_W-1:0];
endmodule

// File: rtl/ssb_period_calc.sv
module ssb_period_calc
  import ssb_pkg::*;
(
  input  logic [BASE_W-1:0] base_sel,
  input  logic [DEV_W-1:0]  dev_sel,
  input  logic [RND_W-1:0]  rnd,
  output ticks_t            total
);
  logic [RND_W-1:0] extra;

  always_comb begin
    extra = rnd & dev_mask(dev_sel);
    total = base_ticks(base_sel) + ticks_t'(extra);
  end
endmodule

// File: rtl/ssb_bit_timer.sv
module ssb_bit_timer
  import ssb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  ticks_t total,
  output logic   load_evt,
  output ticks_t remain,
  output ticks_t period,
  output logic   bit_clk
);
  ticks_t low_len;

  // a bit ends when one tick is left; count 0 only occurs before the first load
  assign load_evt = enable && (remain <= ticks_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain  <= '0;
      period  <= '0;
      low_len <= '0;
    end else if (load_evt) begin
      remain  <= total;
      period  <= total;
      low_len <= total - (total >> 1);
    end else if (enable) begin
      remain  <= remain - ticks_t'(1);
    end
  end

  assign bit_clk = enable && (remain > low_len);
endmodule

// File: rtl/ssb_clock_spreader.sv
module ssb_clock_spreader
  import ssb_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 24'h5A5A5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [BASE_W-1:0] base_sel,
  input  logic [DEV_W-1:0]  dev_sel,
  output logic              bit_clk,
  output logic [CNT_W-1:0]  bit_remain,
  output logic [CNT_W-1:0]  bit_period
);
  logic             load_evt;
  logic [RND_W-1:0] rnd;
  ticks_t           total;

  ssb_prbs #(.SEED(SEED)) i_prbs (
    .clk(clk), .rst_n(rst_n), .step(load_evt), .rnd(rnd)
  );

  ssb_period_calc i_calc (
    .base_sel(base_sel), .dev_sel(dev_sel), .rnd(rnd), .total(total)
  );

  ssb_bit_timer i_timer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .total(total),
    .load_evt(load_evt), .remain(bit_remain), .period(bit_period),
    .bit_clk(bit_clk)
  );
endmodule

// File: rtl/ssb_spread_checker.sv
module ssb_spread_checker
  import ssb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic [BASE_W-1:0] base_sel,
  input logic [DEV_W-1:0]  dev_sel,
  input logic              load_evt,
  input logic              bit_clk,
  input logic [CNT_W-1:0]  bit_remain,
  input logic [CNT_W-1:0]  bit_period
);
  assert_hold_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !bit_clk);

  assert_hold_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(bit_remain) && $stable(bit_period));

  assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !load_evt) |=> bit_remain == $past(bit_remain) - 1'b1);

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> bit_remain == bit_period);

  assert_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (bit_period >= base_ticks($past(base_sel))) &&
                 (bit_period <= base_ticks($past(base_sel)) + ticks_t'(dev_mask($past(dev_sel)))));

  assert_last_tick_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_remain == 1) |-> !bit_clk);
endmodule

bind ssb_clock_spreader ssb_spread_checker i_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .base_sel(base_sel),
  .dev_sel(dev_sel), .load_evt(load_evt), .bit_clk(bit_clk),
  .bit_remain(bit_remain), .bit_period(bit_period)
);

// File: tb/test_ssb_clock_spreader.sv
module test_ssb_clock_spreader;
  localparam int W = ssb_pkg::CNT_W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         enable = 1'b0;
  logic [7:0]   base_sel = 8'd0;
  logic [2:0]   dev_sel = 3'd0;
  logic         bit_clk;
  logic [W-1:0] bit_remain;
  logic [W-1:0] bit_period;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [23:0] m_lfsr = 24'h5A5A5A;

  always #5 clk = ~clk;

  ssb_clock_spreader i_ssb_clock_spreader (
    .clk(clk), .rst_n(rst_n), .enable(enable), .base_sel(base_sel),
    .dev_sel(dev_sel), .bit_clk(bit_clk), .bit_remain(bit_remain),
    .bit_period(bit_period)
  );

  function automatic logic [23:0] model_next(input logic [23:0] s);
    logic fb;
    fb = s[23] ^ s[22] ^ s[21] ^ s[16];
    return (s << 1) | {23'd0, fb};
  endfunction

  function automatic int model_mask(input int d);
    return (d >= 7) ? 127 : ((1 << (d + 1)) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // entered at the sampling edge of a bit's first cycle; leaves at the next bit's first cycle
  task automatic run_bits(input int n, input int nb, input int nd, input bit pause);
    for (int i = 0; i < n; i++) begin
      int p;
      int hi;
      int len;
      hi = 0;
      len = 0;
      p = 320 + 2 * int'(base_sel) + (int'(m_lfsr[6:0]) & model_mask(int'(dev_sel)));
      chk(int'(bit_period) == p, "R2 R3 R4 bit length", int'(bit_period), p);
      chk(int'(bit_remain) == p, "R2 first-cycle count", int'(bit_remain), p);
      m_lfsr = model_next(m_lfsr);
      do begin
        if (bit_clk) hi++;
        len++;
        if (i == 0 && len == 10) begin
          base_sel = 8'(nb);
          dev_sel  = 3'(nd);
        end
        if (pause && i == 0 && len == 20) begin
          int r;
          r = int'(bit_remain);
          enable = 1'b0;
          for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            chk(bit_clk == 1'b0, "R8 clock low while disabled", int'(bit_clk), 0);
            chk(int'(bit_remain) == r, "R8 count frozen", int'(bit_remain), r);
          end
          enable = 1'b1;
        end
        @(negedge clk);
      end while (bit_remain != bit_period);
      chk(len == p, "R5 R7 bit duration", len, p);
      chk(hi == p / 2, "R6 high phase", hi, p / 2);
    end
  endtask

  initial begin
    int bases[6];
    int idx;
    bases = '{0, 1, 77, 128, 200, 255};
    repeat (3) @(negedge clk);
    chk(bit_clk == 1'b0, "R1 clock in reset", int'(bit_clk), 0);
    chk(int'(bit_remain) == 0, "R1 count in reset", int'(bit_remain), 0);
    chk(int'(bit_period) == 0, "R1 length in reset", int'(bit_period), 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(int'(bit_remain) == 0, "R8 no load while disabled", int'(bit_remain), 0);
    chk(bit_clk == 1'b0, "R8 clock low before enable", int'(bit_clk), 0);
    base_sel = 8'(bases[0]);
    dev_sel  = 3'd0;
    enable = 1'b1;
    @(negedge clk);
    chk(bit_remain == bit_period && bit_remain != 0, "R8 first load at first enabled edge",
        int'(bit_remain), int'(bit_period));
    idx = 0;
    for (int d = 0; d < 8; d++) begin
      for (int b = 0; b < 6; b++) begin
        int nxt;
        nxt = idx + 1;
        run_bits(2, bases[nxt % 6], (nxt / 6) % 8, (idx % 7) == 3);
        idx++;
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule